// File: doc/BRIEF.md
# Read Data Parity Checker with Machine-Check Capture

This block sits beside the read path of a 64-bit data bus that carries one parity bit per byte. In every clock where the data-ready strobe is high during a read cycle, it checks even parity on each byte whose byte enable is set. It reports the result on an active-low status output exactly two clocks later. Each failing transfer gives one low clock on that output.

When a failing transfer arrives while the capture-enable input is high, the block records the cycle's address and control word in a set of machine-check registers and sets a valid flag. The first capture is held until software clears the flag, so a later error never overwrites it. If the machine-check-enable control bit is also 1 at that capture, the block raises a request flag. The sequencer takes that flag at the next instruction boundary and keeps it asserted until it pulses acknowledge.

Top module: `rdpar_mc_top`

## Requirements
- R1: A byte is in error when the XOR of its 8 data bits (byte k is data_i[8k+7:8k]) and its parity bit par_i[k] is 1. A transfer fails when any enabled byte is in error.
- R2: A byte whose enable be_i[k] is 0 never produces an error, whatever its data and parity.
- R3: pchk_n_o is low in the clock two clocks after a failing transfer clock, and high two clocks after any other clock. Back-to-back failing transfers give back-to-back low clocks.
- R4: Only clocks with xfer_rdy_i=1 and rd_i=1 are transfers. A clock with rd_i=0 never produces an error.
- R5: A failing transfer with cap_en_i=1 and mc_valid_o=0 loads addr_i into mc_addr_o and ctl_i into mc_ctl_o, and sets mc_valid_o. All three are visible in the following clock.
- R6: A failing transfer with cap_en_i=0 captures nothing. mc_valid_o stays 0.
- R7: While mc_valid_o=1, further errors do not change mc_addr_o or mc_ctl_o. The flag stays set until clr_valid_i=1 clears it.
- R8: mc_req_o rises only in the clock after a capture made while mce_i=1. A capture made while mce_i=0 leaves mc_req_o at 0.
- R9: mc_req_o stays 1 until a clock with ack_i=1. If ack_i=1 in the same clock as a new capture with mce_i=1, mc_req_o stays 1.
- R10: A synchronous active-high reset drives pchk_n_o high and clears mc_valid_o and mc_req_o in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_rdy_i | input | 1 | Data-ready strobe, one transfer per high clock |
| rd_i | input | 1 | Current cycle is a read |
| be_i | input | 8 | Byte enables of the current cycle, active high |
| data_i | input | 64 | Read data |
| par_i | input | 8 | Per-byte even parity bits |
| cap_en_i | input | 1 | Capture enable for machine-check registers |
| addr_i | input | 32 | Address of the current cycle |
| ctl_i | input | 4 | Control word of the current cycle |
| mce_i | input | 1 | Machine-check-enable control bit |
| clr_valid_i | input | 1 | Clears the capture valid flag |
| ack_i | input | 1 | Acknowledges the request flag |
| pchk_n_o | output | 1 | Active-low parity status, two clocks behind the strobe |
| mc_valid_o | output | 1 | Machine-check registers hold a capture |
| mc_addr_o | output | 32 | Captured address |
| mc_ctl_o | output | 4 | Captured control word |
| mc_req_o | output | 1 | Machine-check request flag |

## Verification
The assertions assume that address, control and enables are stable and valid in every strobe clock, and that reset is held for at least two clocks so that the status pipeline has been flushed before the two-clock checks apply. They also treat clr_valid_i and ack_i as ordinary single-clock controls that may coincide with a transfer. The stimulus drives every input on the falling edge, holds reset for several clocks, and builds each transfer from correct parity before it flips chosen parity bits. This keeps every error a deliberate one on a known byte.

// File: rtl/rdpar_pkg.sv
package rdpar_pkg;
  localparam int BYTE_W = 8;

  // even parity: data bits plus parity bit must hold an even count of ones
  function automatic logic byte_par_err(input logic [BYTE_W-1:0] d, input logic p);
    return (^d) ^ p;
  endfunction

  typedef struct packed {
    logic rd;
    logic strobe;
  } xfer_t;

  function automatic logic is_read_xfer(input xfer_t x);
    return x.rd & x.strobe;
  endfunction
endpackage

// File: rtl/rdpar_lane_chk.sv
module rdpar_lane_chk
  import rdpar_pkg::*;
#(
  parameter int NB = 8,
  localparam int DW = NB * BYTE_W
) (
  input  logic [DW-1:0] data,
  input  logic [NB-1:0] par,
  input  logic [NB-1:0] be,
  output logic [NB-1:0] lane_err
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_err[g] = be[g] & byte_par_err(data[g*BYTE_W +: BYTE_W], par[g]);
  end
endmodule

// File: rtl/rdpar_stat_pipe.sv
module rdpar_stat_pipe #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic err_in,
  output logic stat_n
);
  logic [DEPTH-1:0] sh;

  if (DEPTH == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= err_in;
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[DEPTH-2:0], err_in};
    end
  end

  assign stat_n = ~sh[DEPTH-1];
endmodule

// File: rtl/rdpar_mc_cap.sv
module rdpar_mc_cap #(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          err_now,
  input  logic          cap_en,
  input  logic          mce,
  input  logic          clr_valid,
  input  logic          ack,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] ctl,
  output logic          cap_hit,
  output logic          req_set,
  output logic          valid_q,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] ctl_q,
  output logic          req_q
);
  assign cap_hit = err_now & cap_en & ~valid_q;
  assign req_set = cap_hit & mce;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      req_q   <= 1'b0;
      addr_q  <= '0;
      ctl_q   <= '0;
    end else begin
      if (cap_hit) begin
        valid_q <= 1'b1;
        addr_q  <= addr;
        ctl_q   <= ctl;
      end else if (clr_valid) begin
        valid_q <= 1'b0;
      end
      req_q <= req_set | (req_q & ~ack);
    end
  end
endmodule

// File: rtl/rdpar_mc_top.sv
module rdpar_mc_top
  import rdpar_pkg::*;
#(
  parameter int NB    = 8,
  parameter int AW    = 32,
  parameter int CW    = 4,
  parameter int LAT   = 2,
  localparam int DW   = NB * BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_rdy_i,
  input  logic          rd_i,
  input  logic [NB-1:0] be_i,
  input  logic [DW-1:0] data_i,
  input  logic [NB-1:0] par_i,
  input  logic          cap_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] ctl_i,
  input  logic          mce_i,
  input  logic          clr_valid_i,
  input  logic          ack_i,
  output logic          pchk_n_o,
  output logic          mc_valid_o,
  output logic [AW-1:0] mc_addr_o,
  output logic [CW-1:0] mc_ctl_o,
  output logic          mc_req_o
);
  logic [NB-1:0] lane_err;
  logic          xfer_now;
  logic          err_now;
  logic          cap_hit;
  logic          req_set;
  xfer_t         xf;

  assign xf       = '{rd: rd_i, strobe: xfer_rdy_i};
  assign xfer_now = is_read_xfer(xf);

  rdpar_lane_chk #(.NB(NB)) u_lane (
    .data     (data_i),
    .par      (par_i),
    .be       (be_i),
    .lane_err (lane_err)
  );

  assign err_now = xfer_now & (|lane_err);

  rdpar_stat_pipe #(.DEPTH(LAT)) u_pipe (
    .clk    (clk),
    .rst    (rst),
    .err_in (err_now),
    .stat_n (pchk_n_o)
  );

  rdpar_mc_cap #(.AW(AW), .CW(CW)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .err_now   (err_now),
    .cap_en    (cap_en_i),
    .mce       (mce_i),
    .clr_valid (clr_valid_i),
    .ack       (ack_i),
    .addr      (addr_i),
    .ctl       (ctl_i),
    .cap_hit   (cap_hit),
    .req_set   (req_set),
    .valid_q   (mc_valid_o),
    .addr_q    (mc_addr_o),
    .ctl_q     (mc_ctl_o),
    .req_q     (mc_req_o)
  );
endmodule

// File: rtl/rdpar_mc_chk.sv
module rdpar_mc_chk #(
  parameter int NB = 8,
  parameter int AW = 32,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          xfer_rdy_i,
  input logic          rd_i,
  input logic [NB-1:0] be_i,
  input logic          cap_en_i,
  input logic          mce_i,
  input logic          clr_valid_i,
  input logic          ack_i,
  input logic          err_now,
  input logic          cap_hit,
  input logic          pchk_n_o,
  input logic          mc_valid_o,
  input logic [AW-1:0] mc_addr_o,
  input logic [CW-1:0] mc_ctl_o,
  input logic          mc_req_o
);
  // R3: failing transfer gives a low status two clocks later
  a_r3_err_low: assert property (@(posedge clk) disable iff (rst)
    err_now |-> ##2 !pchk_n_o);
  // R3: any other clock gives high status two clocks later
  a_r3_ok_high: assert property (@(posedge clk) disable iff (rst)
    !err_now |-> ##2 pchk_n_o);
  // R2: all bytes disabled never errs
  a_r2_masked: assert property (@(posedge clk) disable iff (rst)
    (xfer_rdy_i && be_i == '0) |-> ##2 pchk_n_o);
  // R4: writes never err
  a_r4_write: assert property (@(posedge clk) disable iff (rst)
    (!rd_i) |-> ##2 pchk_n_o);
  // R6: no capture without enable
  a_r6_nocap: assert property (@(posedge clk) disable iff (rst)
    (!mc_valid_o && !cap_en_i) |=> !mc_valid_o);
  // R7: capture held while valid and not cleared
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (mc_valid_o && !clr_valid_i) |=> (mc_valid_o && $stable(mc_addr_o) && $stable(mc_ctl_o)));
  // R8: request only rises after a capture with mce set
  a_r8_req_src: assert property (@(posedge clk) disable iff (rst)
    $rose(mc_req_o) |-> $past(cap_hit && mce_i));
  // R9: request held until acknowledge
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (mc_req_o && !ack_i) |=> mc_req_o);
  // R10: reset clears outputs
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (pchk_n_o && !mc_valid_o && !mc_req_o));
endmodule

bind rdpar_mc_top rdpar_mc_chk #(.NB(NB), .AW(AW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .xfer_rdy_i  (xfer_rdy_i),
  .rd_i        (rd_i),
  .be_i        (be_i),
  .cap_en_i    (cap_en_i),
  .mce_i       (mce_i),
  .clr_valid_i (clr_valid_i),
  .ack_i       (ack_i),
  .err_now     (err_now),
  .cap_hit     (cap_hit),
  .pchk_n_o    (pchk_n_o),
  .mc_valid_o  (mc_valid_o),
  .mc_addr_o   (mc_addr_o),
  .mc_ctl_o    (mc_ctl_o),
  .mc_req_o    (mc_req_o)
);

// File: tb/sim_rdpar_mc_top.sv
`timescale 1ns/1ps
module sim_rdpar_mc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xfer_rdy_i = 0, rd_i = 0, cap_en_i = 0, mce_i = 0, clr_valid_i = 0, ack_i = 0;
  logic [7:0]  be_i = 0, par_i = 0;
  logic [63:0] data_i = 0;
  logic [31:0] addr_i = 0;
  logic [3:0]  ctl_i = 0;
  logic        pchk_n_o, mc_valid_o, mc_req_o;
  logic [31:0] mc_addr_o;
  logic [3:0]  mc_ctl_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rdpar_mc_top u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // correct even parity computed by counting ones
  function automatic logic [7:0] good_par(input logic [63:0] d);
    logic [7:0] p;
    for (int k = 0; k < 8; k++) p[k] = ($countones(d[8*k +: 8]) % 2) == 1;
    return p;
  endfunction

  task automatic idle();
    xfer_rdy_i = 0; rd_i = 0; be_i = 0; clr_valid_i = 0; ack_i = 0;
  endtask

  // drive one transfer clock; flip = parity bits to corrupt
  task automatic xfer(input logic rd, input logic [7:0] be, input logic [63:0] d,
                      input logic [7:0] flip, input logic [31:0] a, input logic [3:0] c);
    xfer_rdy_i = 1; rd_i = rd; be_i = be; data_i = d;
    par_i = good_par(d) ^ flip; addr_i = a; ctl_i = c;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R10 pchk_n after reset", pchk_n_o, 1);
    chk("R10 valid after reset", mc_valid_o, 0);
    chk("R10 req after reset", mc_req_o, 0);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_good();
    xfer(1, 8'hFF, 64'h0123_4567_89AB_CDEF, 8'h00, 32'h10, 4'h1);
    @(negedge clk);
    chk("R1 good read stays high", pchk_n_o, 1);
    @(negedge clk);
  endtask

  task automatic t_single();
    xfer(1, 8'hFF, 64'hDEAD_BEEF_0000_FFFF, 8'h08, 32'h20, 4'h2);
    chk("R3 high one clock after", pchk_n_o, 1);
    @(negedge clk);
    chk("R1 byte3 error low two clocks after", pchk_n_o, 0);
    @(negedge clk);
    chk("R3 single low clock", pchk_n_o, 1);
  endtask

  task automatic t_masked();
    xfer(1, 8'hDF, 64'h5555_AAAA_1234_5678, 8'h20, 32'h30, 4'h3);
    @(negedge clk);
    chk("R2 disabled bad byte ignored", pchk_n_o, 1);
    xfer(1, 8'h00, 64'h1, 8'hFF, 32'h31, 4'h3);
    @(negedge clk);
    chk("R2 no bytes enabled ignored", pchk_n_o, 1);
    @(negedge clk);
  endtask

  task automatic t_write();
    xfer(0, 8'hFF, 64'h7, 8'hFF, 32'h40, 4'h4);
    @(negedge clk);
    chk("R4 write ignored", pchk_n_o, 1);
    @(negedge clk);
  endtask

  task automatic t_b2b();
    xfer_rdy_i = 1; rd_i = 1; be_i = 8'hFF; data_i = 64'h11; par_i = good_par(64'h11) ^ 8'h01;
    @(negedge clk);
    data_i = 64'h22; par_i = good_par(64'h22) ^ 8'h80;
    @(negedge clk);
    data_i = 64'h33; par_i = good_par(64'h33);
    chk("R3 b2b first low", pchk_n_o, 0);
    @(negedge clk);
    idle();
    chk("R3 b2b second low", pchk_n_o, 0);
    @(negedge clk);
    chk("R3 b2b then high", pchk_n_o, 1);
    @(negedge clk);
  endtask

  task automatic t_nocap();
    cap_en_i = 0; mce_i = 1;
    xfer(1, 8'hFF, 64'h9, 8'h02, 32'h50, 4'h5);
    chk("R6 no capture without enable", mc_valid_o, 0);
    chk("R8 no request without capture", mc_req_o, 0);
    @(negedge clk);
    mce_i = 0;
  endtask

  task automatic t_cap();
    cap_en_i = 1; mce_i = 0;
    xfer(1, 8'hFF, 64'hABC, 8'h04, 32'hCAFE_0001, 4'hA);
    chk("R5 valid set", mc_valid_o, 1);
    chk("R5 address captured", mc_addr_o, 32'hCAFE_0001);
    chk("R5 control captured", mc_ctl_o, 4'hA);
    chk("R8 mce=0 no request", mc_req_o, 0);
    xfer(1, 8'hFF, 64'hABD, 8'h01, 32'hBEEF_0002, 4'h5);
    @(negedge clk);
    chk("R7 address held", mc_addr_o, 32'hCAFE_0001);
    chk("R7 control held", mc_ctl_o, 4'hA);
    chk("R7 valid held", mc_valid_o, 1);
    clr_valid_i = 1;
    @(negedge clk);
    clr_valid_i = 0;
    chk("R7 cleared by software", mc_valid_o, 0);
  endtask

  task automatic t_req();
    cap_en_i = 1; mce_i = 1;
    xfer(1, 8'hFF, 64'h77, 8'h10, 32'h600, 4'h6);
    chk("R8 request raised", mc_req_o, 1);
    repeat (3) @(negedge clk);
    chk("R9 request held", mc_req_o, 1);
    ack_i = 1;
    @(negedge clk);
    ack_i = 0;
    chk("R9 request cleared by ack", mc_req_o, 0);
    clr_valid_i = 1;
    @(negedge clk);
    clr_valid_i = 0;
  endtask

  task automatic t_collide();
    xfer(1, 8'hFF, 64'h88, 8'h40, 32'h700, 4'h7);
    chk("R9 request up before collision", mc_req_o, 1);
    clr_valid_i = 1;
    @(negedge clk);
    clr_valid_i = 0;
    xfer_rdy_i = 1; rd_i = 1; be_i = 8'hFF; data_i = 64'h99;
    par_i = good_par(64'h99) ^ 8'h02; addr_i = 32'h701; ack_i = 1;
    @(negedge clk);
    idle();
    chk("R9 ack with new capture keeps request", mc_req_o, 1);
    chk("R5 new capture address", mc_addr_o, 32'h701);
    ack_i = 1;
    @(negedge clk);
    ack_i = 0;
    chk("R9 later ack clears", mc_req_o, 0);
  endtask

  task automatic t_reset_mid();
    xfer(1, 8'hFF, 64'h5, 8'h01, 32'h800, 4'h8);
    rst = 1;
    @(negedge clk);
    chk("R10 mid reset pchk_n high", pchk_n_o, 1);
    chk("R10 mid reset valid clear", mc_valid_o, 0);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_good();
    t_single();
    t_masked();
    t_write();
    t_b2b();
    t_nocap();
    t_cap();
    t_req();
    t_collide();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule